// File: doc/BRIEF.md
# Programmable Counter Array Timebase

This block is the shared 16-bit timebase behind a set of compare/capture channels. It counts up from reset and wraps from all ones to zero. Each increment comes from one of four sources picked by software: two fixed divisions of the system clock, a pulse from a neighbouring timer's overflow, or falling edges on an external pin. Software starts and stops counting through a run bit. It can also choose to freeze the count while the chip is in its idle state.

Two flags live beside the counter. The wrap flag is set when the counter rolls over. The channel event flag is set by a strobe from the attached compare/capture channel. Both flags feed one interrupt request. The wrap flag only contributes when its enable bit is set.

Software reaches the block through two byte-wide registers, a mode byte and a control byte, each with its own write strobe and a read-back output. The compare/capture channels and the watchdog use the counter value. They are outside this block. The watchdog-enable bit is only stored here.

Top module: `cnt_array_tbase`

## Requirements
- R1: After reset the count is 0, both register read-backs are 8'h00 and the interrupt request is low.
- R2: The count advances only while the run bit (control bit 0) is 1. While the run bit is 0 the count holds its value.
- R3: With source select (mode bits 2:1) at 2'b00, the count advances exactly once in every 12 clock cycles.
- R4: With source select at 2'b01, the count advances exactly once in every 4 clock cycles.
- R5: With source select at 2'b10, the count advances once for each clock cycle in which `t0_ovf` is high.
- R6: With source select at 2'b11, the count advances once for each falling edge of `ext_pin`. This holds when the pin stays high and low for at least 4 clock cycles each. The edge shows up in the count within 4 cycles.
- R7: With idle gating (mode bit 3) at 1 and `idle` high, the count holds. With idle gating at 0, counting continues while `idle` is high.
- R8: A wrap of the count from 16'hFFFF to 16'h0000 sets the wrap flag (control bit 1). The flag stays set until software writes 0 to it. A software write of 1 to that bit also sets it.
- R9: A hardware set of the wrap flag or the event flag in the same cycle as a software write of 0 to it leaves the flag set.
- R10: The channel event flag (control bit 2) is set by a one-cycle high on `mc_strobe`. A software write of 0 clears it. A software write of 1 to it changes nothing.
- R11: `irq` is high exactly when the event flag is set, or when the wrap flag and the wrap interrupt enable (mode bit 0) are both set.
- R12: Writes to reserved bits (mode 7:5, control 7:3) have no effect, and those bits read as 0. The watchdog-enable bit (mode bit 4) is stored and read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all fixed divisions are taken from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode byte |
| mode_wdata | input | 8 | Mode byte write data |
| ctrl_we | input | 1 | Write strobe for the control byte |
| ctrl_wdata | input | 8 | Control byte write data |
| t0_ovf | input | 1 | Overflow pulse from the neighbouring timer |
| ext_pin | input | 1 | Asynchronous external count pin |
| idle | input | 1 | Chip idle indication |
| mc_strobe | input | 1 | Match/capture event from the attached channel |
| mode_rd | output | 8 | Mode byte read-back |
| ctrl_rd | output | 8 | Control byte read-back |
| count | output | 16 | Current counter value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the wrap flag being set by hardware in the same cycle that software clears it. That needs a rollover from 16'hFFFF, which the slow sources would take hundreds of thousands of cycles to reach. The stimulus picks the timer-overflow source and holds `t0_ovf` high, so the count advances every cycle. It reads the count, works out how many cycles remain to the wrap, and places the control write of 0 on exactly that last cycle. The event-flag version of the same collision is produced directly by driving `mc_strobe` alongside the clearing write.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  typedef enum logic [1:0] {
    SRC_SLOW = 2'b00,
    SRC_FAST = 2'b01,
    SRC_TMR  = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  // mode byte field positions
  localparam int unsigned MB_IE   = 0;
  localparam int unsigned MB_SRC  = 1;
  localparam int unsigned MB_GATE = 3;
  localparam int unsigned MB_WD   = 4;
  // control byte field positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_OVF  = 1;
  localparam int unsigned CB_EVT  = 2;
endpackage

// File: rtl/tbase_divider.sv
module tbase_divider #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] ph_q, ph_d;

  always_comb begin
    tick = (ph_q == LAST);
    ph_d = tick ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/tbase_pin_edge.sv
module tbase_pin_edge #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [SYNC:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[SYNC-1:0], pin};
    fall = sr_q[SYNC] & ~sr_q[SYNC-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/tbase_flags.sv
module tbase_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_ovf,
  input  logic hw_evt,
  input  logic wr,
  input  logic wr_ovf,
  input  logic wr_evt,
  output logic ovf_q,
  output logic evt_q
);
  logic ovf_d, evt_d;

  always_comb begin
    ovf_d = hw_ovf | (wr ? wr_ovf : ovf_q);
    evt_d = hw_evt | (wr ? (evt_q & wr_evt) : evt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      evt_q <= evt_d;
    end
  end

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !wr |=> ovf_q);
  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ovf |=> ovf_q);
  p_evt_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> evt_q);
  p_evt_no_sw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_q && !hw_evt |=> !evt_q);
endmodule

// File: rtl/cnt_array_tbase.sv
module cnt_array_tbase
  import tbase_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SLOW_DIV = 12,
  parameter int unsigned FAST_DIV = 4,
  parameter int unsigned PIN_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_we,
  input  logic [7:0]       mode_wdata,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             t0_ovf,
  input  logic             ext_pin,
  input  logic             idle,
  input  logic             mc_strobe,
  output logic [7:0]       mode_rd,
  output logic [7:0]       ctrl_rd,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic slow_tick, fast_tick, pin_fall;
  logic ie_q, wd_q, gate_q, run_q;
  logic ie_d, wd_d, gate_d, run_d;
  src_e src_q, src_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic src_tick, cnt_en, wrap;
  logic ovf_q, evt_q;

  tbase_divider #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst_n(rst_n), .tick(slow_tick));
  tbase_divider #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst_n(rst_n), .tick(fast_tick));
  tbase_pin_edge #(.SYNC(PIN_SYNC)) u_pin (.clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall(pin_fall));

  // register next state
  always_comb begin
    ie_d   = ie_q;
    wd_d   = wd_q;
    gate_d = gate_q;
    src_d  = src_q;
    run_d  = run_q;
    if (mode_we) begin
      ie_d   = mode_wdata[MB_IE];
      wd_d   = mode_wdata[MB_WD];
      gate_d = mode_wdata[MB_GATE];
      src_d  = src_e'(mode_wdata[MB_SRC +: 2]);
    end
    if (ctrl_we) run_d = ctrl_wdata[CB_RUN];
  end

  // count source and counter next state
  always_comb begin
    unique case (src_q)
      SRC_SLOW: src_tick = slow_tick;
      SRC_FAST: src_tick = fast_tick;
      SRC_TMR:  src_tick = t0_ovf;
      default:  src_tick = pin_fall;
    endcase
    cnt_en = run_q & ~(idle & gate_q) & src_tick;
    wrap   = cnt_en & (cnt_q == CNT_MAX);
    cnt_d  = cnt_en ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      wd_q   <= 1'b0;
      gate_q <= 1'b0;
      src_q  <= SRC_SLOW;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ie_q   <= ie_d;
      wd_q   <= wd_d;
      gate_q <= gate_d;
      src_q  <= src_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
    end
  end

  tbase_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .hw_ovf(wrap), .hw_evt(mc_strobe),
    .wr(ctrl_we), .wr_ovf(ctrl_wdata[CB_OVF]), .wr_evt(ctrl_wdata[CB_EVT]),
    .ovf_q(ovf_q), .evt_q(evt_q)
  );

  always_comb begin
    mode_rd = {3'b000, wd_q, gate_q, src_q, ie_q};
    ctrl_rd = {5'b00000, evt_q, ovf_q, run_q};
    count   = cnt_q;
    irq     = (ovf_q & ie_q) | evt_q;
  end

  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cnt_q));
  p_idle_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle && gate_q |=> $stable(cnt_q));
  p_wrap_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && (cnt_q == CNT_MAX) |=> ovf_q && (cnt_q == '0));
  p_irq_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> irq);
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_q && !evt_q |-> !irq);
endmodule

// File: tb/sim_cnt_array_tbase.sv
module sim_cnt_array_tbase;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_we = 1'b0, ctrl_we = 1'b0;
  logic [7:0] mode_wdata = '0, ctrl_wdata = '0;
  logic t0_ovf = 1'b0, ext_pin = 1'b1, idle = 1'b0, mc_strobe = 1'b0;
  logic [7:0] mode_rd, ctrl_rd;
  logic [15:0] count;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  cnt_array_tbase u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .t0_ovf(t0_ovf),
    .ext_pin(ext_pin), .idle(idle), .mc_strobe(mc_strobe),
    .mode_rd(mode_rd), .ctrl_rd(ctrl_rd), .count(count), .irq(irq)
  );

  typedef struct packed {
    logic        run;
    logic        idl;
    logic        gate;
    logic [1:0]  src;
    logic        t0;
    logic [15:0] cycles;
    logic [15:0] delta;
    logic [7:0]  req;
  } vec_t;

  // run idle gate src t0 cycles delta requirement
  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 16'd1200, 16'd100, 8'd3},  // R3
    '{1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 16'd1200, 16'd300, 8'd4},  // R4
    '{1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 16'd100,  16'd100, 8'd5},  // R5
    '{1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 16'd100,  16'd0,   8'd5},  // R5
    '{1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 16'd400,  16'd0,   8'd2},  // R2
    '{1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 16'd50,   16'd0,   8'd2},  // R2
    '{1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 16'd400,  16'd0,   8'd7},  // R7
    '{1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 16'd400,  16'd100, 8'd7}   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(logic wd, logic gate, logic [1:0] src, logic ie);
    return {3'b000, wd, gate, src, ie};
  endfunction

  task automatic wr_mode(input logic [7:0] d);
    @(negedge clk); mode_we = 1'b1; mode_wdata = d;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin : main
    logic [15:0] c0;
    int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(count), 32'h0);
    check("R1 mode", 32'(mode_rd), 32'h0);
    check("R1 ctrl", 32'(ctrl_rd), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      wr_mode(mbyte(1'b0, VEC[i].gate, VEC[i].src, 1'b0));
      wr_ctrl({7'b0, VEC[i].run});
      idle = VEC[i].idl;
      t0_ovf = VEC[i].t0;
      c0 = count;
      repeat (int'(VEC[i].cycles)) @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), 32'(count - c0), 32'(VEC[i].delta));
      t0_ovf = 1'b0;
      idle = 1'b0;
    end

    // R6 external pin falling edges, 4 high / 4 low
    wr_mode(mbyte(1'b0, 1'b0, 2'b11, 1'b0));
    wr_ctrl(8'h01);
    repeat (6) @(negedge clk);
    c0 = count;
    for (int p = 0; p < 20; p++) begin
      ext_pin = 1'b0; repeat (4) @(negedge clk);
      ext_pin = 1'b1; repeat (4) @(negedge clk);
    end
    check("R6 pin edges", 32'(count - c0), 32'd20);
    ext_pin = 1'b0; repeat (4) @(negedge clk);
    check("R6 last edge latency", 32'(count - c0), 32'd21);
    ext_pin = 1'b1;

    // R8 / R9 wrap with simultaneous software clear
    wr_mode(mbyte(1'b0, 1'b0, 2'b10, 1'b0));
    @(negedge clk);
    c0 = count;
    k = 65536 - int'(c0);
    t0_ovf = 1'b1;
    repeat (k - 1) @(posedge clk);
    @(negedge clk);
    check("R8 flag before wrap", 32'(ctrl_rd[1]), 32'h0);
    ctrl_we = 1'b1; ctrl_wdata = 8'h01;
    @(negedge clk);
    ctrl_we = 1'b0; t0_ovf = 1'b0;
    check("R8 count wrapped", 32'(count), 32'h0);
    check("R9 wrap flag wins over clear", 32'(ctrl_rd[1]), 32'h1);
    check("R11 wrap masked", 32'(irq), 32'h0);
    repeat (10) @(negedge clk);
    check("R8 flag sticky", 32'(ctrl_rd[1]), 32'h1);
    wr_mode(mbyte(1'b0, 1'b0, 2'b10, 1'b1));
    check("R11 wrap enabled", 32'(irq), 32'h1);
    wr_ctrl(8'h01);
    check("R8 software clear", 32'(ctrl_rd[1]), 32'h0);
    check("R11 irq drops", 32'(irq), 32'h0);
    wr_ctrl(8'h03);
    check("R8 software set", 32'(ctrl_rd[1]), 32'h1);
    wr_ctrl(8'h01);

    // R10 event flag
    @(negedge clk); mc_strobe = 1'b1;
    @(negedge clk); mc_strobe = 1'b0;
    check("R10 event set", 32'(ctrl_rd[2]), 32'h1);
    check("R11 event irq", 32'(irq), 32'h1);
    wr_ctrl(8'h05);
    check("R10 write one keeps", 32'(ctrl_rd[2]), 32'h1);
    wr_ctrl(8'h01);
    check("R10 write zero clears", 32'(ctrl_rd[2]), 32'h0);
    wr_ctrl(8'h05);
    check("R10 write one cannot set", 32'(ctrl_rd[2]), 32'h0);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 8'h01; mc_strobe = 1'b1;
    @(negedge clk); ctrl_we = 1'b0; mc_strobe = 1'b0;
    check("R9 event wins over clear", 32'(ctrl_rd[2]), 32'h1);
    wr_ctrl(8'h00);

    // R12 reserved bits and watchdog bit
    wr_mode(8'hFF);
    check("R12 mode readback", 32'(mode_rd), 32'h1F);
    wr_ctrl(8'hF9);
    check("R12 ctrl readback", 32'(ctrl_rd), 32'h01);
    wr_mode(8'hE0);
    check("R12 mode reserved only", 32'(mode_rd), 32'h00);

    done = 1'b1;
    finish_run();
  end
endmodule